// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Stored Condition Flags

This block is the integer execution core of a small processor datapath. It combines two N-bit two's-complement operands under a 4-bit operation select and presents the result combinationally. The operations are addition, subtraction, negation, increment and decrement, carry-chained addition and subtraction, compare, bit test, and the bitwise functions. Alongside the result it derives four condition bits: negative, zero, signed overflow and carry. These bits go into a flag register on the next clock edge when the flag-update input is high.

A three-bit condition select reads the stored flags and reports whether a conditional branch would be taken. Compare and test change only the flags. They lower the write-back strobe so that the surrounding datapath discards their result. Codes 13 to 15 of the operation select are reserved. They neither write back nor touch the flags.

Top module: `alu_flagged`

## Requirements
- R1: Operation codes on `op_sel` are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 test, 6 AND, 7 OR, 8 XOR, 9 negate (0-A), 10 complement (~A), 11 increment (A+1), 12 decrement (A-1). Arithmetic results wrap modulo 2^W, and C is the carry out of the top bit.
- R2: V is set exactly when the carry into the most significant bit differs from the carry out of it. A carry out by itself (0xFF+0x01) leaves V clear.
- R3: Subtract, compare, negate and decrement add the inverted second operand plus a carry-in. C=1 therefore means no borrow: 0xF0-0x14 gives 0xDC with N=1, Z=0, V=0, C=1.
- R4: Add-with-carry uses the stored C as carry-in. Subtract-with-borrow computes A+~B+C, with the stored C as the not-borrow.
- R5: N equals bit W-1 of the result. Z is set when every result bit is zero.
- R6: Compare and test update the flags and hold `res_wr` low. All other valid codes drive `res_wr` high.
- R7: Test, AND, OR, XOR and complement clear V and keep the stored C.
- R8: With `flag_en` low the stored flags keep their value whatever the operation.
- R9: `br_sel` codes: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=0, 5 N=1, 6 V=1, 7 V=0. `br_taken` is evaluated on the stored flags.
- R10: Reset (`rst_n` low) clears all four stored flags.
- R11: Reserved codes 13 to 15 hold `res_wr` low and leave the flags unchanged even with `flag_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_sel | input | 4 | Operation select |
| flag_en | input | 1 | Store the new flags at the clock edge |
| br_sel | input | 3 | Branch condition select |
| result | output | W | Operation result (combinational) |
| res_wr | output | 1 | Result is to be written back |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |
| br_taken | output | 1 | Selected condition holds on the stored flags |

## Verification
Additions are tried with two small positives, 0x7F+1, 0xFF+1 and 0x80+0x80. These four cases separate signed overflow from a plain carry and show the case where both occur. Subtraction and negation use the 0xF0-0x14 case, the most negative operand and zero, which exercise the borrow polarity and the overflow of negating the minimum value. The carry-chained operations are run once with C clear and once with C set, to show that the stored carry is consumed. All eight branch codes are swept on two opposite flag patterns. Alongside these, flag-hold, reserved codes and logical operations are tried after the carry was set and after it was cleared, so that a forced or lost carry shows up.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_TST = 4'd5;
  localparam logic [3:0] OP_AND = 4'd6;
  localparam logic [3:0] OP_OR  = 4'd7;
  localparam logic [3:0] OP_XOR = 4'd8;
  localparam logic [3:0] OP_NEG = 4'd9;
  localparam logic [3:0] OP_NOT = 4'd10;
  localparam logic [3:0] OP_INC = 4'd11;
  localparam logic [3:0] OP_DEC = 4'd12;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_msb
);
  localparam int LW = W - 1;

  logic [LW:0] lo;
  logic [1:0]  hi;

  always_comb begin
    lo   = {1'b0, x[LW-1:0]} + {1'b0, y[LW-1:0]} + {{LW{1'b0}}, cin};
    hi   = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, lo[LW]};
    sum  = {hi[0], lo[LW-1:0]};
    cout = hi[1];
    c_msb = lo[LW];
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flagged_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         c_old,
  output logic [W-1:0] res,
  output cc_t          cc_nxt,
  output logic         wr,
  output logic         valid
);
  logic [W-1:0] ax, ay, sum, lres;
  logic         acin, cout, c_msb, use_arith;

  alu_adder #(.W(W)) u_add (
    .x(ax), .y(ay), .cin(acin), .sum(sum), .cout(cout), .c_msb(c_msb)
  );

  always_comb begin
    ax        = a;
    ay        = b;
    acin      = 1'b0;
    use_arith = 1'b1;
    lres      = '0;
    wr        = 1'b1;
    valid     = 1'b1;
    case (op)
      OP_ADD: ;
      OP_ADC: acin = c_old;
      OP_SUB: begin ay = ~b; acin = 1'b1; end
      OP_CMP: begin ay = ~b; acin = 1'b1; wr = 1'b0; end
      OP_SBB: begin ay = ~b; acin = c_old; end
      OP_NEG: begin ax = '0; ay = ~a; acin = 1'b1; end
      OP_INC: begin ay = '0; acin = 1'b1; end
      OP_DEC: begin ay = '1; end
      OP_TST: begin use_arith = 1'b0; lres = a & b; wr = 1'b0; end
      OP_AND: begin use_arith = 1'b0; lres = a & b; end
      OP_OR:  begin use_arith = 1'b0; lres = a | b; end
      OP_XOR: begin use_arith = 1'b0; lres = a ^ b; end
      OP_NOT: begin use_arith = 1'b0; lres = ~a; end
      default: begin use_arith = 1'b0; wr = 1'b0; valid = 1'b0; end
    endcase
    res      = use_arith ? sum : lres;
    cc_nxt.n = res[W-1];
    cc_nxt.z = ~|res;
    cc_nxt.v = use_arith & (cout ^ c_msb);
    cc_nxt.c = use_arith ? cout : c_old;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flagged_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  cc_t  d,
  output cc_t  q
);
  cc_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (upd) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));
endmodule

// File: rtl/alu_br_eval.sv
module alu_br_eval
  import alu_flagged_pkg::*;
(
  input  cc_t        cc,
  input  logic [2:0] sel,
  output logic       taken
);
  logic hit;

  always_comb begin
    case (sel[2:1])
      2'd0:    hit = cc.z;
      2'd1:    hit = cc.c;
      2'd2:    hit = cc.n;
      default: hit = cc.v;
    endcase
    // odd codes test the flag clear, except the sign pair which is inverted
    taken = (sel[2:1] == 2'd2) ? (hit ^ ~sel[0]) : (hit ^ sel[0]);
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_flagged_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic         flag_en,
  input  logic [2:0]   br_sel,
  output logic [W-1:0] result,
  output logic         res_wr,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         br_taken
);
  cc_t  cc_q, cc_d;
  logic op_ok;
  logic is_logic;

  alu_datapath #(.W(W)) u_dp (
    .a(op_a), .b(op_b), .op(op_sel), .c_old(cc_q.c),
    .res(result), .cc_nxt(cc_d), .wr(res_wr), .valid(op_ok)
  );

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_en & op_ok), .d(cc_d), .q(cc_q)
  );

  alu_br_eval u_br (.cc(cc_q), .sel(br_sel), .taken(br_taken));

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;

  assign is_logic = (op_sel == OP_TST) || (op_sel == OP_AND) || (op_sel == OP_OR) ||
                    (op_sel == OP_XOR) || (op_sel == OP_NOT);

  // R2
  add_ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_ADD && cc_d.v) |->
      (op_a[W-1] == op_b[W-1] && result[W-1] != op_a[W-1]));

  // R3
  sub_noborrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_SUB) |-> (cc_d.c == (op_a >= op_b)));

  // R7
  logic_vclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_logic) |=> !flag_v);

  // R7
  logic_ckeep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_logic) |=> (flag_c == $past(flag_c)));

  // R11
  rsvd_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_DEC) |-> !res_wr);
endmodule

// File: tb/sim_alu_flagged.sv
module sim_alu_flagged;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [3:0] op_sel = '0;
  logic       flag_en = 1'b0;
  logic [2:0] br_sel = '0;
  logic [7:0] result;
  logic       res_wr, flag_n, flag_z, flag_v, flag_c, br_taken;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  alu_flagged #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_en(flag_en), .br_sel(br_sel), .result(result), .res_wr(res_wr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .br_taken(br_taken)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then clock the flags in
  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic en,
                       input logic [7:0] exp_res, input logic exp_wr);
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; flag_en = en;
    #1;
    if (exp_wr) chk({tag, " result"}, int'(result), int'(exp_res));
    chk({tag, " res_wr"}, int'(res_wr), int'(exp_wr));
    @(posedge clk); #1;
    flag_en = 1'b0;
  endtask

  task automatic chk_cc(input string tag, input logic [3:0] nzvc);
    chk({tag, " flags NZVC"}, int'({flag_n, flag_z, flag_v, flag_c}), int'(nzvc));
  endtask

  task automatic chk_br(input string tag, input logic [7:0] exp_map);
    for (int i = 0; i < 8; i++) begin
      br_sel = 3'(i); #1;
      chk($sformatf("%s br_sel=%0d", tag, i), int'(br_taken), int'(exp_map[i]));
    end
  endtask

  task automatic t_reset;
    chk_cc("R10 reset", 4'b0000);
  endtask

  task automatic t_add;
    apply("R1 add 5+3", 4'd0, 8'h05, 8'h03, 1, 8'h08, 1); chk_cc("R1 add 5+3", 4'b0000);
    apply("R2 add 7F+1", 4'd0, 8'h7F, 8'h01, 1, 8'h80, 1); chk_cc("R2 add 7F+1", 4'b1010);
    chk_br("R9 after 7F+1", 8'b0110_1010);
    apply("R2 add FF+1", 4'd0, 8'hFF, 8'h01, 1, 8'h00, 1); chk_cc("R2 R5 add FF+1", 4'b0101);
    chk_br("R9 after FF+1", 8'b1001_0101);
    apply("R2 add 80+80", 4'd0, 8'h80, 8'h80, 1, 8'h00, 1); chk_cc("R2 add 80+80", 4'b0111);
  endtask

  task automatic t_sub;
    apply("R3 sub F0-14", 4'd2, 8'hF0, 8'h14, 1, 8'hDC, 1); chk_cc("R3 sub F0-14", 4'b1001);
    apply("R3 sub 80-1", 4'd2, 8'h80, 8'h01, 1, 8'h7F, 1); chk_cc("R3 sub 80-1", 4'b0011);
    apply("R3 sub 1-2", 4'd2, 8'h01, 8'h02, 1, 8'hFF, 1); chk_cc("R3 sub 1-2", 4'b1000);
  endtask

  task automatic t_chain;
    apply("R4 set C", 4'd0, 8'hFF, 8'h01, 1, 8'h00, 1);
    apply("R4 adc C=1", 4'd1, 8'h10, 8'h20, 1, 8'h31, 1); chk_cc("R4 adc C=1", 4'b0000);
    apply("R4 adc C=0", 4'd1, 8'h10, 8'h20, 1, 8'h30, 1);
    apply("R4 sbb C=0", 4'd3, 8'h10, 8'h01, 1, 8'h0E, 1); chk_cc("R4 sbb C=0", 4'b0001);
    apply("R4 sbb C=1", 4'd3, 8'h10, 8'h01, 1, 8'h0F, 1);
  endtask

  task automatic t_cmp_tst;
    apply("R6 cmp 5,5", 4'd4, 8'h05, 8'h05, 1, 8'h00, 0); chk_cc("R6 cmp 5,5", 4'b0101);
    apply("R6 tst F0,0F", 4'd5, 8'hF0, 8'h0F, 1, 8'h00, 0); chk_cc("R6 R7 tst", 4'b0101);
  endtask

  task automatic t_logic;
    apply("R1 and", 4'd6, 8'hCC, 8'hAA, 1, 8'h88, 1); chk_cc("R7 and C kept 1", 4'b1001);
    apply("R1 or", 4'd7, 8'hCC, 8'hAA, 1, 8'hEE, 1);
    apply("R1 clr C", 4'd0, 8'h00, 8'h00, 1, 8'h00, 1); chk_cc("R5 zero", 4'b0100);
    apply("R1 xor", 4'd8, 8'h80, 8'h00, 1, 8'h80, 1); chk_cc("R7 xor C kept 0", 4'b1000);
    apply("R2 set V", 4'd0, 8'h7F, 8'h01, 1, 8'h80, 1);
    apply("R1 not", 4'd10, 8'h0F, 8'h00, 1, 8'hF0, 1); chk_cc("R7 not V cleared", 4'b1000);
  endtask

  task automatic t_unary;
    apply("R3 neg 1", 4'd9, 8'h01, 8'h00, 1, 8'hFF, 1); chk_cc("R3 neg 1", 4'b1000);
    apply("R2 neg 80", 4'd9, 8'h80, 8'h00, 1, 8'h80, 1); chk_cc("R2 neg 80", 4'b1010);
    apply("R3 neg 0", 4'd9, 8'h00, 8'h00, 1, 8'h00, 1); chk_cc("R3 neg 0", 4'b0101);
    apply("R1 inc 7F", 4'd11, 8'h7F, 8'h00, 1, 8'h80, 1); chk_cc("R2 inc 7F", 4'b1010);
    apply("R1 inc FF", 4'd11, 8'hFF, 8'h00, 1, 8'h00, 1); chk_cc("R1 inc FF", 4'b0101);
    apply("R1 dec 0", 4'd12, 8'h00, 8'h00, 1, 8'hFF, 1); chk_cc("R3 dec 0", 4'b1000);
    apply("R1 dec 80", 4'd12, 8'h80, 8'h00, 1, 8'h7F, 1); chk_cc("R2 dec 80", 4'b0011);
  endtask

  task automatic t_hold;
    apply("R8 add no en", 4'd0, 8'hFF, 8'h01, 0, 8'h00, 1); chk_cc("R8 hold", 4'b0011);
    apply("R8 sub no en", 4'd2, 8'h01, 8'h02, 0, 8'hFF, 1); chk_cc("R8 hold 2", 4'b0011);
  endtask

  task automatic t_rsvd;
    for (int k = 13; k < 16; k++) begin
      apply("R11 reserved", 4'(k), 8'h00, 8'h00, 1, 8'h00, 0);
      chk_cc("R11 reserved flags", 4'b0011);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_chain();
    t_cmp_tst();
    t_logic();
    t_unary();
    t_hold();
    t_rsvd();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule